// File: doc/BRIEF.md
# PAL Composite Sync and Video Timing Generator

This block turns a 24 MHz clock into a progressive, PAL-style composite timing stream. It drives a two-level sync output and a one-bit video output. Each field is built from a sequence of timed slots selected by a status counter. First come ten broad-pulse half-lines. Then come ten equalising half-lines. A picture burst of 304 full lines follows, and twelve more equalising half-lines close the field before the counter wraps to the start.

During each picture line the block emits a horizontal sync pulse and then a back porch. It then shifts out one pixel per `PIX_DIV` clocks, taking the pixels from bytes it reads through a framebuffer read port, most significant bit first. The video output is held low everywhere outside the pixel window. A one-cycle debug strobe marks the first cycle of every field, so that measurement equipment has a fixed trigger point.

Cycle counts are parameters. The defaults give 48 cycles for a 2 µs interval, 720 cycles for a 30 µs interval and 1536 cycles for a 64 µs line.

Top module: `pal_sync_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `syncOut`=1, `videoOut`=0, `dbgStrobe`=0 and `fbAddr`=`FB_BASE`. The first cycle after reset is released begins slot 0 of a new field.
- R2: The slot order within a field is fixed.
  - Status values 0 to 9 are broad half-lines.
  - Status values 10 to 19 are equalising half-lines.
  - Status value 20 is the picture burst.
  - Status values 21 to 32 are trailing equalising half-lines.
  - After status 32, and for any status value above 32, the field restarts at status 0.
  - A field therefore holds 10+10+`PIC_LINES`+12 falling edges on `syncOut`.
- R3: A broad half-line drives `syncOut` low for `CYC_LONG` cycles (default 720) and then high for `CYC_SHORT` cycles (default 48).
- R4: An equalising half-line, whether leading or trailing, drives `syncOut` low for `CYC_SHORT` cycles and then high for `CYC_LONG` cycles.
- R5: The picture burst consists of `PIC_LINES` consecutive lines of `LINE_CYC` cycles each. In every line, `syncOut` is low for the first `HSYNC_CYC` cycles and high for the rest of the line.
- R6: Pixel output follows a fixed layout.
  - **Window:** pixel `i` of a line (0-based) is shown on `videoOut` for `PIX_DIV` cycles, starting `HSYNC_CYC`+`BPORCH_CYC`+`i*PIX_DIV` cycles after the line starts.
  - **Source bit:** its value is bit `7-(i%8)` of the byte read at framebuffer address `FB_BASE + line*(PIX_PER_LINE/8) + i/8`.
  - **Read port:** `fbData` must reflect `fbAddr` in the same cycle (combinational read).
  - **Blanking:** outside the window, `videoOut` is 0.
- R7: `videoOut` is 0 in every cycle in which `syncOut` is 0.
- R8: The first trailing equalising pulse begins in the cycle directly after the last cycle of the last picture line, with no idle cycle between them.
- R9: `dbgStrobe` is high for exactly one cycle per field. That cycle is the first low cycle of the field's first broad pulse.
- R10: `fbAddr` equals `FB_BASE` from the first cycle of each field until the first byte fetch. It increases by one per byte fetched, and reaches `FB_BASE + PIC_LINES*PIX_PER_LINE/8` by the end of the picture burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock (24 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| fbAddr | output | ADDR_W | Framebuffer byte address |
| fbData | input | 8 | Framebuffer byte at `fbAddr`, same cycle |
| syncOut | output | 1 | Composite sync level, 0 = sync tip |
| videoOut | output | 1 | Monochrome pixel level |
| dbgStrobe | output | 1 | One-cycle pulse at field start |

## Verification
Different kinds of internal fault show up at the ports with different delays:
- **Slot counter:** a fault here changes a pulse width or the pulse count of a field. The per-cycle comparison sees it within one half-line, and the falling-edge count catches it at the end of the field.
- **Pixel counters:** a fault here moves or flips video bits inside the first byte of the first line that uses them.
- **Address counter:** a fault here shows as wrong pixel data in the following byte. It is also caught by the address checks at field start and at the end of the burst.
- **Reset:** a mid-burst reset must return every output to its idle value after the next edge and restart a clean field.

// File: rtl/pal_timing_pkg.sv
package pal_timing_pkg;

  // Per-cycle strobes from the field sequencer to the output datapath.
  typedef struct packed {
    logic syncLow;     // composite sync at tip level this cycle
    logic pixActive;   // inside the pixel window of a picture line
    logic loadByte;    // first pixel of a byte: fetch and show bit 7
    logic shiftPix;    // later pixel of a byte: show next bit
    logic fieldStart;  // first cycle of status 0
  } palStrobes_t;

endpackage

// File: rtl/pal_field_seq.sv
module pal_field_seq
  import pal_timing_pkg::*;
#(
  parameter int CYC_SHORT    = 48,
  parameter int CYC_LONG     = 720,
  parameter int LINE_CYC     = 1536,
  parameter int HSYNC_CYC    = 96,
  parameter int BPORCH_CYC   = 192,
  parameter int PIX_DIV      = 4,
  parameter int PIX_PER_LINE = 256,
  parameter int PIC_LINES    = 304,
  parameter int LONG_SLOTS   = 10,
  parameter int SHORT_SLOTS  = 10,
  parameter int TRAIL_SLOTS  = 12
) (
  input  logic        clk,
  input  logic        rst,
  output palStrobes_t strobes
);

  localparam int SLOT_CYC  = CYC_LONG + CYC_SHORT;
  localparam int CNT_MAX   = (LINE_CYC > SLOT_CYC) ? LINE_CYC : SLOT_CYC;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam int ST_PIC    = LONG_SLOTS + SHORT_SLOTS;
  localparam int ST_LAST   = ST_PIC + TRAIL_SLOTS;
  localparam int ST_W      = $clog2(ST_LAST + 2);
  localparam int LN_W      = $clog2(PIC_LINES + 1);
  localparam int DIV_W     = $clog2(PIX_DIV + 1);
  localparam int ACT_START = HSYNC_CYC + BPORCH_CYC;
  localparam int ACT_END   = ACT_START + PIX_PER_LINE * PIX_DIV;

  localparam logic [CNT_W-1:0] C_SHORT   = CNT_W'(CYC_SHORT);
  localparam logic [CNT_W-1:0] C_LONG    = CNT_W'(CYC_LONG);
  localparam logic [CNT_W-1:0] C_HSYNC   = CNT_W'(HSYNC_CYC);
  localparam logic [CNT_W-1:0] C_ACT0    = CNT_W'(ACT_START);
  localparam logic [CNT_W-1:0] C_ACT1    = CNT_W'(ACT_END);
  localparam logic [CNT_W-1:0] SLOT_LAST = CNT_W'(SLOT_CYC - 1);
  localparam logic [CNT_W-1:0] LINE_LAST = CNT_W'(LINE_CYC - 1);
  localparam logic [ST_W-1:0]  S_SHORT0  = ST_W'(LONG_SLOTS);
  localparam logic [ST_W-1:0]  S_PIC     = ST_W'(ST_PIC);
  localparam logic [ST_W-1:0]  S_LAST    = ST_W'(ST_LAST);
  localparam logic [LN_W-1:0]  LN_LAST   = LN_W'(PIC_LINES - 1);
  localparam logic [DIV_W-1:0] DIV_LAST  = DIV_W'(PIX_DIV - 1);

  logic [ST_W-1:0]  status;
  logic [CNT_W-1:0] cnt;
  logic [LN_W-1:0]  lineIdx;
  logic [DIV_W-1:0] divCnt;
  logic [2:0]       bitCnt;

  logic             isPic;
  logic             isLong;
  logic             badStatus;
  logic             slotEnd;
  logic [CNT_W-1:0] cntLast;

  // Slot decode: which kind of interval the current status selects.
  always_comb begin
    isPic     = (status == S_PIC);
    isLong    = (status < S_SHORT0);
    badStatus = (status > S_LAST);
    cntLast   = isPic ? LINE_LAST : SLOT_LAST;
    slotEnd   = (cnt == cntLast);
  end

  // Strobes for the datapath, all derived from the current state.
  always_comb begin
    strobes = '0;
    if (isLong)     strobes.syncLow = (cnt < C_LONG);
    else if (isPic) strobes.syncLow = (cnt < C_HSYNC);
    else            strobes.syncLow = (cnt < C_SHORT);
    strobes.pixActive  = isPic && (cnt >= C_ACT0) && (cnt < C_ACT1);
    strobes.loadByte   = strobes.pixActive && (divCnt == '0) && (bitCnt == 3'd0);
    strobes.shiftPix   = strobes.pixActive && (divCnt == '0) && (bitCnt != 3'd0);
    strobes.fieldStart = (status == '0) && (cnt == '0);
  end

  // Status, slot cycle and picture line counters.
  always_ff @(posedge clk) begin
    if (rst) begin
      status  <= '0;
      cnt     <= '0;
      lineIdx <= '0;
    end else if (badStatus) begin
      status  <= '0;
      cnt     <= '0;
      lineIdx <= '0;
    end else if (slotEnd) begin
      cnt <= '0;
      if (isPic) begin
        if (lineIdx == LN_LAST) begin
          lineIdx <= '0;
          status  <= status + 1'b1;
        end else begin
          lineIdx <= lineIdx + 1'b1;
        end
      end else if (status == S_LAST) begin
        status <= '0;
      end else begin
        status <= status + 1'b1;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // Pixel pacing within the active window.
  always_ff @(posedge clk) begin
    if (rst || !strobes.pixActive) begin
      divCnt <= '0;
      bitCnt <= 3'd0;
    end else if (divCnt == DIV_LAST) begin
      divCnt <= '0;
      bitCnt <= bitCnt + 3'd1;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

endmodule

// File: rtl/pal_pix_path.sv
module pal_pix_path
  import pal_timing_pkg::*;
#(
  parameter int                ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] FB_BASE = 16'h0100
) (
  input  logic              clk,
  input  logic              rst,
  input  palStrobes_t       strobes,
  input  logic [7:0]        fbData,
  output logic [ADDR_W-1:0] fbAddr,
  output logic              syncOut,
  output logic              videoOut,
  output logic              dbgStrobe
);

  logic [ADDR_W-1:0] addrQ;
  logic [6:0]        shReg;
  logic              syncQ;
  logic              vidQ;
  logic              dbgQ;

  // Output levels: one register stage behind the sequencer.
  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ <= 1'b1;
      dbgQ  <= 1'b0;
    end else begin
      syncQ <= !strobes.syncLow;
      dbgQ  <= strobes.fieldStart;
    end
  end

  // Framebuffer address walker.
  always_ff @(posedge clk) begin
    if (rst || strobes.fieldStart) addrQ <= FB_BASE;
    else if (strobes.loadByte)     addrQ <= addrQ + 1'b1;
  end

  // Byte capture and serialisation, MSB first; blank outside window.
  always_ff @(posedge clk) begin
    if (rst) begin
      shReg <= '0;
      vidQ  <= 1'b0;
    end else if (strobes.loadByte) begin
      shReg <= fbData[6:0];
      vidQ  <= fbData[7];
    end else if (strobes.shiftPix) begin
      shReg <= {shReg[5:0], 1'b0};
      vidQ  <= shReg[6];
    end else if (!strobes.pixActive) begin
      vidQ  <= 1'b0;
    end
  end

  assign fbAddr    = addrQ;
  assign syncOut   = syncQ;
  assign videoOut  = vidQ;
  assign dbgStrobe = dbgQ;

endmodule

// File: rtl/pal_sync_gen.sv
module pal_sync_gen
  import pal_timing_pkg::*;
#(
  parameter int                CYC_SHORT    = 48,
  parameter int                CYC_LONG     = 720,
  parameter int                LINE_CYC     = 1536,
  parameter int                HSYNC_CYC    = 96,
  parameter int                BPORCH_CYC   = 192,
  parameter int                PIX_DIV      = 4,
  parameter int                PIX_PER_LINE = 256,
  parameter int                PIC_LINES    = 304,
  parameter int                LONG_SLOTS   = 10,
  parameter int                SHORT_SLOTS  = 10,
  parameter int                TRAIL_SLOTS  = 12,
  parameter int                ADDR_W       = 16,
  parameter logic [ADDR_W-1:0] FB_BASE      = 16'h0100
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] fbAddr,
  input  logic [7:0]        fbData,
  output logic              syncOut,
  output logic              videoOut,
  output logic              dbgStrobe
);

  palStrobes_t strobes;

  pal_field_seq #(
    .CYC_SHORT   (CYC_SHORT),
    .CYC_LONG    (CYC_LONG),
    .LINE_CYC    (LINE_CYC),
    .HSYNC_CYC   (HSYNC_CYC),
    .BPORCH_CYC  (BPORCH_CYC),
    .PIX_DIV     (PIX_DIV),
    .PIX_PER_LINE(PIX_PER_LINE),
    .PIC_LINES   (PIC_LINES),
    .LONG_SLOTS  (LONG_SLOTS),
    .SHORT_SLOTS (SHORT_SLOTS),
    .TRAIL_SLOTS (TRAIL_SLOTS)
  ) seqInst (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes)
  );

  pal_pix_path #(
    .ADDR_W (ADDR_W),
    .FB_BASE(FB_BASE)
  ) pathInst (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .fbData   (fbData),
    .fbAddr   (fbAddr),
    .syncOut  (syncOut),
    .videoOut (videoOut),
    .dbgStrobe(dbgStrobe)
  );

endmodule

// File: rtl/pal_sync_gen_chk.sv
module pal_sync_gen_chk #(
  parameter int                CYC_LONG = 720,
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] FB_BASE  = 16'h0100
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] fbAddr,
  input logic              syncOut,
  input logic              videoOut,
  input logic              dbgStrobe
);

  // Length of the current run of low sync cycles, counted at the ports.
  int lowRun;
  always_ff @(posedge clk) begin
    if (rst || syncOut) lowRun <= 0;
    else                lowRun <= lowRun + 1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (syncOut && !videoOut && !dbgStrobe && fbAddr == FB_BASE));

  assert_low_max_R3: assert property (@(posedge clk) disable iff (rst)
    !syncOut |-> (lowRun < CYC_LONG));

  assert_blank_in_sync_R7: assert property (@(posedge clk) disable iff (rst)
    !syncOut |-> !videoOut);

  assert_dbg_single_R9: assert property (@(posedge clk) disable iff (rst)
    dbgStrobe |=> !dbgStrobe);

  assert_dbg_on_tip_R9: assert property (@(posedge clk) disable iff (rst)
    dbgStrobe |-> !syncOut);

  assert_addr_base_R10: assert property (@(posedge clk) disable iff (rst)
    dbgStrobe |-> (fbAddr == FB_BASE));

  assert_addr_step_R10: assert property (@(posedge clk) disable iff (rst)
    (!dbgStrobe && fbAddr != $past(fbAddr)) |-> (fbAddr == $past(fbAddr) + 1'b1));

endmodule

bind pal_sync_gen pal_sync_gen_chk #(
  .CYC_LONG(CYC_LONG),
  .ADDR_W  (ADDR_W),
  .FB_BASE (FB_BASE)
) chkInst (
  .clk      (clk),
  .rst      (rst),
  .fbAddr   (fbAddr),
  .syncOut  (syncOut),
  .videoOut (videoOut),
  .dbgStrobe(dbgStrobe)
);

// File: tb/pal_sync_gen_test.sv
module pal_sync_gen_test;

  localparam int T_SHORT = 3;
  localparam int T_LONG  = 11;
  localparam int T_LINE  = 50;
  localparam int T_HS    = 5;
  localparam int T_BP    = 7;
  localparam int T_DIV   = 2;
  localparam int T_PIX   = 16;
  localparam int T_LINES = 3;
  localparam int N_LONG  = 10;
  localparam int N_SHORT = 10;
  localparam int N_TRAIL = 12;
  localparam int AW      = 16;
  localparam logic [AW-1:0] BASE = 16'h0100;

  localparam int SLOT      = T_SHORT + T_LONG;
  localparam int BPL       = T_PIX / 8;
  localparam int ACT0      = T_HS + T_BP;
  localparam int ACT1      = ACT0 + T_PIX * T_DIV;
  localparam int PIC_START = (N_LONG + N_SHORT) * SLOT;
  localparam int PIC_LEN   = T_LINES * T_LINE;
  localparam int FIELD     = PIC_START + PIC_LEN + N_TRAIL * SLOT;
  localparam int FALLS     = N_LONG + N_SHORT + T_LINES + N_TRAIL;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] fbAddr;
  logic [7:0]    fbData;
  logic          syncOut;
  logic          videoOut;
  logic          dbgStrobe;
  logic [7:0]    mem [0:63];

  int  tests = 0;
  int  fails = 0;
  int  k = 0;
  int  fieldNo = 0;
  int  fallCnt = 0;
  logic prevSync = 1'b1;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  assign fbData = mem[6'(fbAddr - BASE)];

  pal_sync_gen #(
    .CYC_SHORT(T_SHORT), .CYC_LONG(T_LONG), .LINE_CYC(T_LINE),
    .HSYNC_CYC(T_HS), .BPORCH_CYC(T_BP), .PIX_DIV(T_DIV),
    .PIX_PER_LINE(T_PIX), .PIC_LINES(T_LINES), .LONG_SLOTS(N_LONG),
    .SHORT_SLOTS(N_SHORT), .TRAIL_SLOTS(N_TRAIL), .ADDR_W(AW), .FB_BASE(BASE)
  ) uut (
    .clk(clk), .rst(rst), .fbAddr(fbAddr), .fbData(fbData),
    .syncOut(syncOut), .videoOut(videoOut), .dbgStrobe(dbgStrobe)
  );

  task automatic check(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (p=%0d)", req, what, act, exp,
               (k - 1) % FIELD);
    end
  endtask

  task automatic fillMem(int mode);
    for (int i = 0; i < 64; i++) begin
      case (mode)
        0: mem[i] = 8'hFF;
        1: mem[i] = (i % 2 == 0) ? 8'h80 : 8'h01;
        2: mem[i] = 8'h00;
        3: mem[i] = 8'hA5;
        default: mem[i] = 8'($urandom);
      endcase
    end
  endtask

  // Expected sync level at field position p.
  function automatic logic expSync(int p);
    int q;
    if (p < N_LONG * SLOT) return !((p % SLOT) < T_LONG);
    if (p < PIC_START) return !((p % SLOT) < T_SHORT);
    q = p - PIC_START;
    if (q < PIC_LEN) return !((q % T_LINE) < T_HS);
    return !(((q - PIC_LEN) % SLOT) < T_SHORT);
  endfunction

  // Expected video level at field position p.
  function automatic logic expVid(int p);
    int q, line, c, idx;
    q = p - PIC_START;
    if (q < 0 || q >= PIC_LEN) return 1'b0;
    line = q / T_LINE;
    c    = q % T_LINE;
    if (c < ACT0 || c >= ACT1) return 1'b0;
    idx = (c - ACT0) / T_DIV;
    return mem[line * BPL + idx / 8][7 - (idx % 8)];
  endfunction

  function automatic string syncReq(int p);
    if (p < N_LONG * SLOT) return "R3";
    if (p < PIC_START) return "R4";
    if (p < PIC_START + PIC_LEN) return "R5";
    return "R4";
  endfunction

  task automatic stepAndCheck();
    int p;
    @(posedge clk);
    @(negedge clk);
    k++;
    p = (k - 1) % FIELD;
    if (p == 5) begin
      fillMem(fieldNo);
      fieldNo++;
    end
    check(syncReq(p), "syncOut", int'(syncOut), int'(expSync(p)));
    check("R6", "videoOut", int'(videoOut), int'(expVid(p)));
    if (!syncOut) check("R7", "video during sync", int'(videoOut), 0);
    check("R9", "dbgStrobe", int'(dbgStrobe), (p == 0) ? 1 : 0);
    if (p == 0) begin
      check("R10", "fbAddr at field start", int'(fbAddr), int'(BASE));
      fallCnt = 0;
    end
    if (p == PIC_START)
      check("R10", "fbAddr at burst start", int'(fbAddr), int'(BASE));
    if (p == PIC_START + PIC_LEN) begin
      check("R8", "trailing pulse starts at once", int'(syncOut), 0);
      check("R10", "fbAddr after burst", int'(fbAddr), int'(BASE) + T_LINES * BPL);
    end
    if (prevSync && !syncOut) fallCnt++;
    prevSync = syncOut;
    if (p == FIELD - 1) check("R2", "sync falls per field", fallCnt, FALLS);
  endtask

  task automatic checkIdle();
    check("R1", "syncOut in reset", int'(syncOut), 1);
    check("R1", "videoOut in reset", int'(videoOut), 0);
    check("R1", "dbgStrobe in reset", int'(dbgStrobe), 0);
    check("R1", "fbAddr in reset", int'(fbAddr), int'(BASE));
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    void'($urandom(32'd1234));
    fillMem(0);
    repeat (5) @(negedge clk);
    checkIdle();
    rst = 1'b0;
    k = 0;
    repeat (5 * FIELD) stepAndCheck();
    // Mid-burst reset while pixels are being shown.
    repeat (PIC_START + 60) stepAndCheck();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    checkIdle();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    k = 0;
    prevSync = 1'b1;
    repeat (2 * FIELD) stepAndCheck();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

endmodule